// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for each beat of a four-beat memory burst. A load cycle captures a full base address from outside. Each advance cycle that follows steps the two lowest address bits through the burst, while every bit above them stays as it was loaded. The burst order is picked by an order-select input and captured at load time. In linear order the low bits count up by one and wrap modulo four. In interleaved order the low bits are the starting offset XORed with a beat count that runs 0, 1, 2, 3.

A memory controller drives one control bit per cycle. That bit either loads a new base address or advances the beat within the current burst. A global clock enable freezes the whole sequencer, whatever the other inputs are doing. The current address is a direct function of the registered state, so it changes only after a clock edge.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset (`rstN` low) is asserted, `curAddr` is all zeros.
- R2: On a clock edge with `clkEn` high and `advLoad` low, `baseAddr` is captured and `curAddr` equals it after that edge. This applies in the middle of a burst too, and the beat count restarts at zero.
- R3: With linear order captured (`orderSel` = 0 at load), each advance edge (`clkEn` high, `advLoad` high) makes the low two bits of `curAddr` one greater, modulo 4. For example, start 1 gives 1, 2, 3, 0.
- R4: With interleaved order captured (`orderSel` = 1 at load), the low two bits equal the start offset XOR a beat count. The beat count is 0 at load and rises by one on each advance. For example, start 1 gives 1, 0, 3, 2 and start 3 gives 3, 2, 1, 0.
- R5: `orderSel` is sampled only on load edges. Changing it during a burst has no effect on the sequence.
- R6: Advances never change bits `ADDR_W-1` down to 2 of `curAddr`, even when the low bits wrap from 3 to 0. For example, base 0x00FF in linear order gives 0x00FF, 0x00FC, 0x00FD, 0x00FE.
- R7: After the fourth beat, further advances wrap within the same four words, so the fifth beat equals the first.
- R8: While `clkEn` is low, neither loads nor advances take effect and `curAddr` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| clkEn | input | 1 | Global clock enable; low freezes all state |
| advLoad | input | 1 | 0 = load base address, 1 = advance beat |
| baseAddr | input | ADDR_W | External base address captured on load |
| orderSel | input | 1 | Burst order captured on load: 0 linear, 1 interleaved |
| curAddr | output | ADDR_W | Word address of the current beat |

## Verification
The hardest cases to reach from the ports are the ones that combine events within a single burst. One is a change of `orderSel` partway through a burst. Another is a reload that arrives while the beat count is not zero. A third is a clock-enable stall during which the load and advance inputs keep changing. Each directed scenario first drives the sequencer into the middle of a burst and then applies the disturbing input. It then compares the following beats against a sequence computed in the bench from the start offset and the captured order. A base address with both low bits set checks that the wrap from 3 to 0 does not carry into bit 2.

// File: rtl/burst_pkg.sv
package burst_pkg;
  localparam int OFF_W = 2;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  typedef struct packed {
    logic load;
    logic step;
  } burst_ctl_t;
endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_pkg::*;
(
  input  logic       clkEn,
  input  logic       advLoad,
  output burst_ctl_t ctl
);
  always_comb begin
    ctl      = '0;
    ctl.load = clkEn & ~advLoad;
    ctl.step = clkEn & advLoad;
  end
endmodule

// File: rtl/burst_datapath.sv
module burst_datapath
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  burst_ctl_t        ctl,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] curAddr,
  output order_e            curMode
);
  localparam int HI_W = ADDR_W - OFF_W;

  logic [HI_W-1:0]  hiQ;
  logic [OFF_W-1:0] offQ;
  logic [OFF_W-1:0] cntQ;
  order_e           modeQ;
  logic [OFF_W-1:0] lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiQ   <= '0;
      offQ  <= '0;
      cntQ  <= '0;
      modeQ <= ORD_LINEAR;
    end else if (ctl.load) begin
      hiQ   <= baseAddr[ADDR_W-1:OFF_W];
      offQ  <= baseAddr[OFF_W-1:0];
      cntQ  <= '0;
      modeQ <= order_e'(orderSel);
    end else if (ctl.step) begin
      cntQ  <= cntQ + 1'b1;
    end
  end

  always_comb begin
    case (modeQ)
      ORD_INTERLEAVE: lowBits = offQ ^ cntQ;
      default:        lowBits = offQ + cntQ;
    endcase
  end

  assign curAddr = {hiQ, lowBits};
  assign curMode = modeQ;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              advLoad,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              orderSel,
  output logic [ADDR_W-1:0] curAddr
);
  burst_ctl_t ctl;
  order_e     curMode;

  burst_ctrl u_ctrl (
    .clkEn   (clkEn),
    .advLoad (advLoad),
    .ctl     (ctl)
  );

  burst_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .baseAddr (baseAddr),
    .orderSel (orderSel),
    .curAddr  (curAddr),
    .curMode  (curMode)
  );
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              advLoad,
  input logic [ADDR_W-1:0] baseAddr,
  input logic              curMode,
  input logic [ADDR_W-1:0] curAddr
);
  assert_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !advLoad) |=> (curAddr == $past(baseAddr)));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advLoad && !curMode) |=> (curAddr[1:0] == $past(curAddr[1:0]) + 2'd1));

  assert_interleave_flip_R4: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advLoad && curMode) |=> (curAddr[0] != $past(curAddr[0])));

  assert_mode_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advLoad) |=> $stable(curMode));

  assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && advLoad) |=> (curAddr[ADDR_W-1:2] == $past(curAddr[ADDR_W-1:2])));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> $stable(curAddr));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clkEn    (clkEn),
  .advLoad  (advLoad),
  .baseAddr (baseAddr),
  .curMode  (curMode),
  .curAddr  (curAddr)
);

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int ADDR_W   = 16;
  localparam int CLK_PER  = 10;
  localparam int WATCHDOG = 200000;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              clkEn = 1'b0;
  logic              advLoad = 1'b1;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic              orderSel = 1'b0;
  logic [ADDR_W-1:0] curAddr;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  burst_addr_gen #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .advLoad(advLoad),
    .baseAddr(baseAddr), .orderSel(orderSel), .curAddr(curAddr)
  );

  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input string req, input logic [ADDR_W-1:0] exp);
    nChecks++;
    if (curAddr !== exp) begin
      nFail++;
      $display("FAIL %s: curAddr=%h expected=%h", req, curAddr, exp);
    end
  endtask

  // one edge; return at the following falling edge with outputs settled
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doLoad(input logic [ADDR_W-1:0] a, input logic ord);
    clkEn = 1'b1; advLoad = 1'b0; baseAddr = a; orderSel = ord;
    tick();
  endtask

  task automatic doAdv();
    clkEn = 1'b1; advLoad = 1'b1;
    tick();
  endtask

  function automatic logic [ADDR_W-1:0] expAddr(input logic [ADDR_W-1:0] b,
                                                input logic ord, input int k);
    logic [1:0] kk = 2'(k);
    logic [1:0] lo = ord ? (b[1:0] ^ kk) : (b[1:0] + kk);
    return {b[ADDR_W-1:2], lo};
  endfunction

  task automatic runBurst(input string req, input logic [ADDR_W-1:0] b, input logic ord);
    doLoad(b, ord);
    check(req, b);
    for (int k = 1; k < 6; k++) begin
      doAdv();
      check(req, expAddr(b, ord, k));
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1", '0);
    tick();
    check("R1", '0);
    rstN = 1'b1;
    tick();
  endtask

  task automatic testLinear();
    runBurst("R3", 16'h1231, 1'b0);
    runBurst("R7", 16'h5A50, 1'b0);
  endtask

  task automatic testCarry();
    doLoad(16'h00FF, 1'b0);
    check("R6", 16'h00FF);
    doAdv(); check("R6", 16'h00FC);
    doAdv(); check("R6", 16'h00FD);
    doAdv(); check("R6", 16'h00FE);
    doAdv(); check("R6", 16'h00FF);
  endtask

  task automatic testInterleave();
    doLoad(16'hABC1, 1'b1);
    check("R4", 16'hABC1);
    doAdv(); check("R4", 16'hABC0);
    doAdv(); check("R4", 16'hABC3);
    doAdv(); check("R4", 16'hABC2);
    doAdv(); check("R7", 16'hABC1);
    runBurst("R4", 16'h7772, 1'b1);
    runBurst("R4", 16'hFFFF, 1'b1);
  endtask

  task automatic testModeLatch();
    doLoad(16'h0101, 1'b0);
    orderSel = 1'b1;
    clkEn = 1'b1; advLoad = 1'b1; tick(); check("R5", 16'h0102);
    tick(); check("R5", 16'h0103);
    doLoad(16'h0202, 1'b1);
    orderSel = 1'b0;
    clkEn = 1'b1; advLoad = 1'b1; tick(); check("R5", 16'h0203);
    tick(); check("R5", 16'h0200);
  endtask

  task automatic testHold();
    doLoad(16'h4442, 1'b0);
    doAdv(); check("R8", 16'h4443);
    clkEn = 1'b0; advLoad = 1'b1; tick(); check("R8", 16'h4443);
    advLoad = 1'b0; baseAddr = 16'h9999; orderSel = 1'b1;
    tick(); check("R8", 16'h4443);
    tick(); check("R8", 16'h4443);
    doAdv(); check("R8", 16'h4440);
  endtask

  task automatic testReload();
    doLoad(16'h1000, 1'b0);
    doAdv(); check("R2", 16'h1001);
    doAdv(); check("R2", 16'h1002);
    doLoad(16'h2003, 1'b1); check("R2", 16'h2003);
    doAdv(); check("R2", 16'h2002);
    doAdv(); check("R2", 16'h2001);
  endtask

  initial begin
    testReset();
    testLinear();
    testCarry();
    testInterleave();
    testModeLatch();
    testHold();
    testReload();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule